// File: doc/BRIEF.md
# Automatic RTS Flow Control with Hysteresis

This block drives the active-low request-to-send output of a serial receiver from the fill level of its receive buffer. The buffer itself is outside the block. The block samples the buffer's current occupancy and the programmed receive trigger level. From these it tells the remote transmitter to stop when the buffer is nearly full, and to start again once enough data has been drained.

Two thresholds are placed a fixed band above and below the trigger level, and the space between them gives hysteresis. Once the pause threshold is reached, RTS# stays high until the occupancy falls to the resume threshold. Inside the band the output keeps its last state, so the line does not chatter while the host reads the buffer.

Automatic control runs only while both the feature-enable input and the RTS control bit are set. With either of them clear, RTS# is simply the inverse of the RTS control bit. The block also flags, independently of the enables, that the occupancy has reached the trigger level. This flag is the condition for the receive-data interrupt.

Top module: `rts_auto_flow`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, rtsN is 1 and rxTrigHit is 0. Reset also clears the paused state.
- R2: Automatic control is active only in a cycle where featEn=1 and rtsCtl=1.
- R3: While automatic control is inactive, rtsN equals the inverse of rtsCtl one clock later, and the paused state is cleared.
- R4: While automatic control is active, a fill level at or above the upper threshold makes rtsN=1 one clock later. The upper threshold is the trigger plus BAND, which is 8 by default (trigger 16 pauses at 24).
- R5: While automatic control is active, a fill level at or below the lower threshold makes rtsN=0 one clock later. The lower threshold is the trigger minus BAND (trigger 16 resumes at 8).
- R6: While automatic control is active, a fill level strictly between the two thresholds leaves rtsN at its previous value, as long as control was also active in the previous cycle.
- R7: A trigger above DEPTH (64) is treated as DEPTH. The upper threshold saturates at DEPTH and the lower threshold saturates at 0.
- R8: rxTrigHit is 1 one clock after a cycle in which the fill level was at or above the clamped trigger. It is 0 otherwise, whatever the values of featEn and rtsCtl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fillLevel | input | 7 | Receive buffer occupancy, 0 to DEPTH |
| trigLevel | input | 7 | Programmed receive trigger level |
| featEn | input | 1 | Enhanced-feature enable for automatic RTS |
| rtsCtl | input | 1 | Modem-control RTS bit |
| rtsN | output | 1 | Request-to-send, active low, registered |
| rxTrigHit | output | 1 | Occupancy has reached the trigger, registered |

## Verification
The hardest situation to reach is a fill level inside the band in each of the two hysteresis states. The same input must give rtsN=1 after a climb to the upper threshold and rtsN=0 after a drain to the lower threshold. The stimulus reaches it with a random walk on the fill level, whose steps are small enough that it crosses each threshold repeatedly. Directed sweeps cover the same ground at trigger levels that saturate either threshold. The enable bits are toggled in the middle of the band, so the bench also covers re-entry into automatic control from the cleared state.

// File: rtl/rts_flow_pkg.sv
package rts_flow_pkg;
  // Compare strobes passed from the level datapath to the flow control
  typedef struct packed {
    logic atUpper;  // fill at or above pause threshold
    logic atLower;  // fill at or below resume threshold
    logic atTrig;   // fill at or above clamped trigger
  } flowCmp_t;
endpackage

// File: rtl/rts_level_cmp.sv
module rts_level_cmp
  import rts_flow_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int BAND  = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] fillLevel,
  input  logic [CNT_W-1:0] trigLevel,
  output flowCmp_t         cmp
);
  localparam int EXT_W = CNT_W + 1;
  localparam logic [EXT_W-1:0] DEPTH_X = EXT_W'(DEPTH);
  localparam logic [EXT_W-1:0] BAND_X  = EXT_W'(BAND);

  logic [EXT_W-1:0] fillX, trigX, trigClamp, upperSum, upperThr, lowerThr;

  always_comb begin
    fillX     = {1'b0, fillLevel};
    trigX     = {1'b0, trigLevel};
    trigClamp = (trigX > DEPTH_X) ? DEPTH_X : trigX;
    upperSum  = trigClamp + BAND_X;
    upperThr  = (upperSum > DEPTH_X) ? DEPTH_X : upperSum;
  end

  generate
    if (BAND == 0) begin : g_noBand
      assign lowerThr = trigClamp;
    end else begin : g_band
      assign lowerThr = (trigClamp < BAND_X) ? '0 : trigClamp - BAND_X;
    end
  endgenerate

  always_comb begin
    cmp.atUpper = (fillX >= upperThr);
    cmp.atLower = (fillX <= lowerThr);
    cmp.atTrig  = (fillX >= trigClamp);
  end
endmodule

// File: rtl/rts_flow_ctrl.sv
module rts_flow_ctrl
  import rts_flow_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     featEn,
  input  logic     rtsCtl,
  input  flowCmp_t cmp,
  output logic     rtsN,
  output logic     rxTrigHit
);
  logic autoOn;
  logic pausedQ, pausedNext;

  always_comb begin
    autoOn = featEn & rtsCtl;
    if (cmp.atUpper)      pausedNext = 1'b1;
    else if (cmp.atLower) pausedNext = 1'b0;
    else                  pausedNext = pausedQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pausedQ   <= 1'b0;
      rtsN      <= 1'b1;
      rxTrigHit <= 1'b0;
    end else begin
      pausedQ   <= autoOn ? pausedNext : 1'b0;
      rtsN      <= autoOn ? pausedNext : ~rtsCtl;
      rxTrigHit <= cmp.atTrig;
    end
  end
endmodule

// File: rtl/rts_auto_flow.sv
module rts_auto_flow
  import rts_flow_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int BAND  = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fillLevel,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic             featEn,
  input  logic             rtsCtl,
  output logic             rtsN,
  output logic             rxTrigHit
);
  flowCmp_t cmpFlags;

  rts_level_cmp #(.DEPTH(DEPTH), .BAND(BAND), .CNT_W(CNT_W)) u_cmp (
    .fillLevel(fillLevel),
    .trigLevel(trigLevel),
    .cmp      (cmpFlags)
  );

  rts_flow_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .featEn   (featEn),
    .rtsCtl   (rtsCtl),
    .cmp      (cmpFlags),
    .rtsN     (rtsN),
    .rxTrigHit(rxTrigHit)
  );
endmodule

// File: rtl/rts_auto_flow_chk.sv
module rts_auto_flow_chk
  import rts_flow_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] fillLevel,
  input logic [CNT_W-1:0] trigLevel,
  input logic             featEn,
  input logic             rtsCtl,
  input logic             rtsN,
  input logic             rxTrigHit,
  input flowCmp_t         cmpFlags
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  logic autoOn;
  assign autoOn = featEn & rtsCtl;

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rstN |=> (rtsN && !rxTrigHit));

  // R3
  manual_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !autoOn |=> (rtsN == !$past(rtsCtl)));

  // R4
  pause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (autoOn && cmpFlags.atUpper) |=> rtsN);

  // R5
  resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (autoOn && cmpFlags.atLower && !cmpFlags.atUpper) |=> !rtsN);

  // R6
  band_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(autoOn) && autoOn && !cmpFlags.atUpper && !cmpFlags.atLower)
    |=> (rtsN == $past(rtsN)));

  // R7
  full_pause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (autoOn && fillLevel >= FULL) |=> rtsN);

  // R7
  empty_resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (autoOn && fillLevel == '0 && trigLevel != '0) |=> !rtsN);

  // R8
  trig_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel >= FULL) |=> rxTrigHit);

  // R8
  trig_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == '0 && trigLevel != '0) |=> !rxTrigHit);
endmodule

bind rts_auto_flow rts_auto_flow_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .fillLevel(fillLevel),
  .trigLevel(trigLevel),
  .featEn   (featEn),
  .rtsCtl   (rtsCtl),
  .rtsN     (rtsN),
  .rxTrigHit(rxTrigHit),
  .cmpFlags (cmpFlags)
);

// File: tb/tb_rts_auto_flow.sv
`timescale 1ns/1ps
module tb_rts_auto_flow;
  localparam int DEPTH = 64;
  localparam int BAND  = 8;
  localparam int CW    = 7;

  logic clk = 1'b0;
  logic rstN;
  logic [CW-1:0] fillLevel, trigLevel;
  logic featEn, rtsCtl;
  logic rtsN, rxTrigHit;

  int compared = 0;
  int mismatched = 0;
  bit mPaused = 1'b0;

  always #2.5 clk = ~clk;

  rts_auto_flow dut (
    .clk(clk), .rstN(rstN), .fillLevel(fillLevel), .trigLevel(trigLevel),
    .featEn(featEn), .rtsCtl(rtsCtl), .rtsN(rtsN), .rxTrigHit(rxTrigHit)
  );

  function automatic int clampTrig(int t);
    return (t > DEPTH) ? DEPTH : t;
  endfunction
  function automatic int upperOf(int t);
    int u = clampTrig(t) + BAND;
    return (u > DEPTH) ? DEPTH : u;
  endfunction
  function automatic int lowerOf(int t);
    int l = clampTrig(t) - BAND;
    return (l < 0) ? 0 : l;
  endfunction

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle at negedge, sample after the next posedge
  task automatic step(int f, int t, bit fe, bit rc, string req);
    bit nextP, expRts, expHit;
    fillLevel = CW'(f); trigLevel = CW'(t); featEn = fe; rtsCtl = rc;
    if (f >= upperOf(t))      nextP = 1'b1;
    else if (f <= lowerOf(t)) nextP = 1'b0;
    else                      nextP = mPaused;
    expRts = (fe && rc) ? nextP : !rc;
    expHit = (f >= clampTrig(t));
    mPaused = (fe && rc) ? nextP : 1'b0;
    @(negedge clk);
    check({req, " rtsN"}, int'(rtsN), int'(expRts));
    check("R8 rxTrigHit", int'(rxTrigHit), int'(expHit));
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int fw;
    void'($urandom(32'd20240611));
    rstN = 1'b0; fillLevel = 7'd40; trigLevel = 7'd16; featEn = 1'b1; rtsCtl = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset rtsN", int'(rtsN), 1);
    check("R1 reset rxTrigHit", int'(rxTrigHit), 0);
    fillLevel = 7'd12;
    rstN = 1'b1;
    mPaused = 1'b0;
    // R1: paused state cleared by reset, so an in-band level resumes
    step(12, 16, 1, 1, "R1 cleared");
    // R4/R5/R6 directed climb and drain around trigger 16
    step(23, 16, 1, 1, "R6 below upper");
    step(24, 16, 1, 1, "R4 pause at 24");
    step(20, 16, 1, 1, "R6 hold paused");
    step(9, 16, 1, 1, "R6 hold at 9");
    step(8, 16, 1, 1, "R5 resume at 8");
    step(20, 16, 1, 1, "R6 hold running");
    // R2/R3 enables
    step(30, 16, 0, 1, "R2 featEn off");
    step(30, 16, 1, 0, "R3 rtsCtl off");
    step(30, 16, 0, 0, "R3 both off");
    step(20, 16, 1, 1, "R3 cleared on reentry");
    step(30, 16, 1, 1, "R4 pause");
    step(20, 16, 0, 1, "R3 drop auto");
    step(20, 16, 1, 1, "R3 paused cleared");
    // R7 saturation
    step(63, 60, 1, 1, "R7 upper sat 63");
    step(64, 60, 1, 1, "R7 upper sat 64");
    step(53, 60, 1, 1, "R7 hold");
    step(52, 60, 1, 1, "R7 lower 52");
    step(9, 2, 1, 1, "R7 upper 10 hold");
    step(10, 2, 1, 1, "R7 pause 10");
    step(1, 2, 1, 1, "R7 hold at 1");
    step(0, 2, 1, 1, "R7 lower sat 0");
    step(60, 100, 1, 1, "R7 clamp trig hold");
    step(64, 100, 1, 1, "R7 clamp trig pause");
    step(56, 100, 1, 1, "R7 clamp lower 56");
    // R8 independent of enables
    step(15, 16, 0, 0, "R8 below trig");
    step(16, 16, 0, 0, "R8 at trig");
    // Random walk over fill, occasional trigger and enable changes
    fw = 16;
    for (int i = 0; i < 3000; i++) begin
      int tr, d;
      bit fe, rc;
      tr = (i / 200) * 9 % 80;
      d = int'($urandom_range(0, 6)) - 3;
      fw = fw + d;
      if (fw < 0) fw = 0;
      if (fw > DEPTH) fw = DEPTH;
      fe = ($urandom_range(0, 19) != 0);
      rc = ($urandom_range(0, 19) != 0);
      step(fw, tr, fe, rc, "R4 R5 R6 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule